// File: doc/BRIEF.md
# Dual-Issue Warp Scheduler

This block is the issue stage of one multiprocessor. Two independent schedulers share the resident warps. Even-numbered warps belong to scheduler 0 and odd-numbered warps to scheduler 1. In every cycle each scheduler may pick one ready warp, and the stage grants one instruction from each picked warp to one of four execution columns. Two of these columns are 16-lane core groups, one is a 16-lane load/store group and one is a 4-lane special-function group.

Each warp presents a valid bit and a 2-bit instruction class. The block grants combinationally in the cycle where the request is seen. It then counts how long every column stays occupied, using a per-column down-counter that is loaded at the grant. A warp whose earlier instruction still holds a column cannot issue again. A double-precision instruction needs both core columns and issues alone.

Top module: `dual_issue_sched`

## Requirements
- R1: After reset no grant is raised, every column reports idle, and both round-robin pointers point at the lowest warp of their scheduler.
- R2: Scheduler 0 grants only even warp IDs and scheduler 1 only odd warp IDs. Each scheduler grants the first ready warp at or after its pointer, in ascending order with wrap-around. The pointer moves to the warp after the granted one only in a cycle where that scheduler issues.
- R3: A warp is ready only when its valid bit is set, no column is still held by an earlier grant to that warp, and the column its class needs is free.
- R4: Class codes are 0 = core (integer or single float), 1 = double float, 2 = load/store and 3 = special function. Column codes are 0 = core A, 1 = core B, 2 = load/store and 3 = special function. A class-0 grant takes core A when it is free and core B otherwise.
- R5: Two grants in the same cycle always go to two different columns, and any mix of classes 0, 2 and 3 may pair.
- R6: A class-1 grant reports column 0 and occupies both core columns. No other grant is raised in that cycle.
- R7: When both schedulers' picks need the same remaining column, scheduler 0 issues and scheduler 1 stalls. A stalled scheduler keeps its pointer.
- R8: A grant at cycle t to a core or load/store column keeps that column unavailable through cycle t+CORE_HOLD-1. The busy output is high in cycles t+1 to t+CORE_HOLD-1 only (CORE_HOLD = 2).
- R9: A grant to the special-function column keeps that column busy in cycles t+1 to t+SFU_HOLD-1 (SFU_HOLD = 8). The other columns keep issuing during that time.
- R10: A warp cannot be granted again while a column it was granted is still busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | NUM_WARPS | Per-warp instruction-present bit |
| warp_cls | input | 2*NUM_WARPS | Per-warp instruction class; warp w uses bits [2w+1:2w] |
| iss_vld | output | 2 | Grant raised by scheduler 0 (bit 0) and scheduler 1 (bit 1) |
| iss_warp0 | output | WID_W | Warp granted by scheduler 0 (zero when no grant) |
| iss_warp1 | output | WID_W | Warp granted by scheduler 1 (zero when no grant) |
| iss_col0 | output | 2 | Column code of scheduler 0's grant |
| iss_col1 | output | 2 | Column code of scheduler 1's grant |
| col_busy | output | 4 | Per-column occupancy from earlier grants, indexed by column code |

## Verification
Grants and column codes are combinational, so they are due in the same cycle as the warp inputs that cause them. Occupancy and in-flight state are due from the cycle after the grant. The column stays busy for CORE_HOLD-1 or SFU_HOLD-1 further cycles. The bench drives new inputs just after each falling edge and compares every output shortly before the next rising edge. It compares against a queue-free integer model, which is then advanced by one cycle to match the registers' update at that edge. Because of this, a busy window that ends one cycle early or late, or a pointer that moves on a stall, shows up in the first cycle where it differs.

// File: rtl/dis_pkg.sv
package dis_pkg;
   typedef enum logic [1:0] {
      CLS_CORE = 2'd0,
      CLS_DBL  = 2'd1,
      CLS_LDST = 2'd2,
      CLS_SFU  = 2'd3
   } icls_e;

   localparam int NCOL      = 4;
   localparam int COL_W     = 2;
   localparam int COL_COREA = 0;
   localparam int COL_COREB = 1;
   localparam int COL_LDST  = 2;
   localparam int COL_SFU   = 3;
endpackage

// File: rtl/dis_rr_picker.sv
module dis_rr_picker #(
   parameter int N = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   input  logic                 adv,
   output logic                 hit,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IW = $clog2(N);

   logic [IW-1:0] ptr;

   // First requester at or after the pointer, wrapping.
   always_comb begin
      int p;
      hit = 1'b0;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         p = int'(ptr) + i;
         if (p >= N) p = p - N;
         if (!hit && req[p]) begin
            hit = 1'b1;
            idx = IW'(p);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        ptr <= '0;
      else if (adv)      ptr <= (int'(idx) == N - 1) ? '0 : idx + 1'b1;
   end

   p_pick_is_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> req[idx]);
   p_adv_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> hit);
   p_ptr_kept_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr));
endmodule

// File: rtl/dis_col_tracker.sv
module dis_col_tracker #(
   parameter int CW    = 3,
   parameter int WID_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [CW-1:0]    load,
   input  logic [WID_W-1:0] owner_in,
   output logic             busy,
   output logic [WID_W-1:0] owner
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         owner <= '0;
      end else if (take) begin
         cnt   <= load;
         owner <= owner_in;
      end else if (cnt != '0) begin
         cnt   <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);

   p_take_only_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !busy);
   p_owner_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !take) |=> $stable(owner));
endmodule

// File: rtl/dis_pair_arb.sv
module dis_pair_arb
   import dis_pkg::*;
(
   input  logic [1:0]      c_vld,
   input  icls_e           c_cls0,
   input  icls_e           c_cls1,
   input  logic [NCOL-1:0] col_free,
   output logic [1:0]      g_vld,
   output logic [COL_W-1:0] g_col0,
   output logic [COL_W-1:0] g_col1,
   output logic [NCOL-1:0] take0,
   output logic [NCOL-1:0] take1
);
   logic [NCOL-1:0] avail;
   logic            s1_ok;

   always_comb begin
      g_vld  = '0;
      g_col0 = '0;
      g_col1 = '0;
      take0  = '0;
      take1  = '0;

      // Scheduler 0 has priority; its pick is already known to fit.
      if (c_vld[0]) begin
         g_vld[0] = 1'b1;
         unique case (c_cls0)
            CLS_CORE: begin
               g_col0 = col_free[COL_COREA] ? COL_W'(COL_COREA) : COL_W'(COL_COREB);
               take0[g_col0] = 1'b1;
            end
            CLS_DBL: begin
               g_col0 = COL_W'(COL_COREA);
               take0[COL_COREA] = 1'b1;
               take0[COL_COREB] = 1'b1;
            end
            CLS_LDST: begin
               g_col0 = COL_W'(COL_LDST);
               take0[COL_LDST] = 1'b1;
            end
            default: begin
               g_col0 = COL_W'(COL_SFU);
               take0[COL_SFU] = 1'b1;
            end
         endcase
      end

      avail = col_free & ~take0;
      s1_ok = c_vld[1] && !(c_vld[0] && c_cls0 == CLS_DBL);

      if (s1_ok) begin
         unique case (c_cls1)
            CLS_CORE: begin
               if (avail[COL_COREA]) begin
                  g_vld[1] = 1'b1;
                  g_col1   = COL_W'(COL_COREA);
               end else if (avail[COL_COREB]) begin
                  g_vld[1] = 1'b1;
                  g_col1   = COL_W'(COL_COREB);
               end
               if (g_vld[1]) take1[g_col1] = 1'b1;
            end
            CLS_DBL: begin
               if (!c_vld[0] && avail[COL_COREA] && avail[COL_COREB]) begin
                  g_vld[1] = 1'b1;
                  g_col1   = COL_W'(COL_COREA);
                  take1[COL_COREA] = 1'b1;
                  take1[COL_COREB] = 1'b1;
               end
            end
            CLS_LDST: begin
               if (avail[COL_LDST]) begin
                  g_vld[1] = 1'b1;
                  g_col1   = COL_W'(COL_LDST);
                  take1[COL_LDST] = 1'b1;
               end
            end
            default: begin
               if (avail[COL_SFU]) begin
                  g_vld[1] = 1'b1;
                  g_col1   = COL_W'(COL_SFU);
                  take1[COL_SFU] = 1'b1;
               end
            end
         endcase
      end
   end

   always_comb begin
      p_no_shared_col_r5: assert ((take0 & take1) == '0);
   end
endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched
   import dis_pkg::*;
#(
   parameter int NUM_WARPS = 48,
   parameter int CORE_HOLD = 2,
   parameter int SFU_HOLD  = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_WARPS-1:0]           warp_valid,
   input  logic [2*NUM_WARPS-1:0]         warp_cls,
   output logic [1:0]                     iss_vld,
   output logic [$clog2(NUM_WARPS/2):0]   iss_warp0,
   output logic [$clog2(NUM_WARPS/2):0]   iss_warp1,
   output logic [COL_W-1:0]               iss_col0,
   output logic [COL_W-1:0]               iss_col1,
   output logic [NCOL-1:0]                col_busy
);
   localparam int PER      = NUM_WARPS / 2;
   localparam int LW       = $clog2(PER);
   localparam int WID_W    = LW + 1;
   localparam int HOLD_MAX = (SFU_HOLD > CORE_HOLD) ? SFU_HOLD : CORE_HOLD;
   localparam int CW       = $clog2(HOLD_MAX);

   if (NUM_WARPS % 2 != 0 || NUM_WARPS < 4) begin : g_bad_warps
      $error("NUM_WARPS must be even and at least 4");
   end
   if (CORE_HOLD < 2 || SFU_HOLD < 2) begin : g_bad_hold
      $error("hold times must be at least 2 cycles");
   end

   logic [NCOL-1:0]  busy;
   logic [WID_W-1:0] owner [NCOL];
   logic [NUM_WARPS-1:0] ready;

   // Readiness of every warp against in-flight state and column occupancy.
   always_comb begin
      for (int w = 0; w < NUM_WARPS; w++) begin
         logic  inflight;
         logic  col_ok;
         icls_e c;
         c = icls_e'(warp_cls[2*w +: 2]);
         inflight = 1'b0;
         for (int k = 0; k < NCOL; k++)
            if (busy[k] && int'(owner[k]) == w) inflight = 1'b1;
         unique case (c)
            CLS_CORE: col_ok = !busy[COL_COREA] || !busy[COL_COREB];
            CLS_DBL:  col_ok = !busy[COL_COREA] && !busy[COL_COREB];
            CLS_LDST: col_ok = !busy[COL_LDST];
            default:  col_ok = !busy[COL_SFU];
         endcase
         ready[w] = warp_valid[w] && !inflight && col_ok;
      end
   end

   logic [1:0]       pick_hit;
   logic [LW-1:0]    pick_idx [2];
   logic [WID_W-1:0] pick_wid [2];
   icls_e            pick_cls [2];
   logic [1:0]       g_vld;

   for (genvar s = 0; s < 2; s++) begin : g_sched
      logic [PER-1:0] req;
      for (genvar j = 0; j < PER; j++) begin : g_req
         assign req[j] = ready[2*j + s];
      end
      dis_rr_picker #(.N(PER)) u_pick (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (req),
         .adv   (g_vld[s]),
         .hit   (pick_hit[s]),
         .idx   (pick_idx[s])
      );
      assign pick_wid[s] = {pick_idx[s], 1'(s)};
      assign pick_cls[s] = icls_e'(warp_cls[2*int'(pick_wid[s]) +: 2]);
   end

   logic [COL_W-1:0] g_col0, g_col1;
   logic [NCOL-1:0]  take0, take1;

   dis_pair_arb u_arb (
      .c_vld    (pick_hit),
      .c_cls0   (pick_cls[0]),
      .c_cls1   (pick_cls[1]),
      .col_free (~busy),
      .g_vld    (g_vld),
      .g_col0   (g_col0),
      .g_col1   (g_col1),
      .take0    (take0),
      .take1    (take1)
   );

   for (genvar k = 0; k < NCOL; k++) begin : g_col
      localparam int HOLD = (k == COL_SFU) ? SFU_HOLD : CORE_HOLD;
      dis_col_tracker #(.CW(CW), .WID_W(WID_W)) u_trk (
         .clk      (clk),
         .rst_n    (rst_n),
         .take     (take0[k] | take1[k]),
         .load     (CW'(HOLD - 1)),
         .owner_in (take0[k] ? pick_wid[0] : pick_wid[1]),
         .busy     (busy[k]),
         .owner    (owner[k])
      );
   end

   assign iss_vld   = g_vld;
   assign iss_warp0 = g_vld[0] ? pick_wid[0] : '0;
   assign iss_warp1 = g_vld[1] ? pick_wid[1] : '0;
   assign iss_col0  = g_vld[0] ? g_col0 : '0;
   assign iss_col1  = g_vld[1] ? g_col1 : '0;
   assign col_busy  = busy;

   p_even_sched0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[0] |-> !iss_warp0[0]);
   p_odd_sched1_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[1] |-> iss_warp1[0]);
   p_grant_free_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[0] |-> !col_busy[iss_col0]);
   p_distinct_cols_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (&iss_vld) |-> (iss_col0 != iss_col1));
   p_dbl_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld[0] && pick_cls[0] == CLS_DBL) |-> !iss_vld[1]);
   p_core_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld[0] && iss_col0 != COL_W'(COL_SFU)) |=> col_busy[$past(iss_col0)]);
   p_sfu_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((iss_vld[0] && iss_col0 == COL_W'(COL_SFU)) ||
       (iss_vld[1] && iss_col1 == COL_W'(COL_SFU))) |=> col_busy[COL_SFU]);
   p_no_reissue_r10: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[0] |=> !(iss_vld[0] && iss_warp0 == $past(iss_warp0)));
endmodule

// File: tb/dual_issue_sched_tb.sv
`timescale 1ns/100ps
module dual_issue_sched_tb;
   localparam int NW    = 48;
   localparam int PER   = NW / 2;
   localparam int CHOLD = 2;
   localparam int SHOLD = 8;
   localparam int WW    = $clog2(PER) + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NW-1:0]   warp_valid = '0;
   logic [2*NW-1:0] warp_cls = '0;
   logic [1:0]      iss_vld;
   logic [WW-1:0]   iss_warp0, iss_warp1;
   logic [1:0]      iss_col0, iss_col1;
   logic [3:0]      col_busy;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dual_issue_sched #(.NUM_WARPS(NW), .CORE_HOLD(CHOLD), .SFU_HOLD(SHOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_cls(warp_cls),
      .iss_vld(iss_vld), .iss_warp0(iss_warp0), .iss_warp1(iss_warp1),
      .iss_col0(iss_col0), .iss_col1(iss_col1), .col_busy(col_busy));

   // Reference state: remaining busy cycles, owner per column, pointers.
   int m_cnt [4];
   int m_own [4];
   int m_ptr [2];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
      end
   endtask

   task automatic step();
      bit rdy [NW];
      bit pv [2]; int pl [2]; int pc [2];
      bit ev [2]; int ec [2];
      bit used [4];
      int exp_busy;
      for (int w = 0; w < NW; w++) begin
         int c; bit inf; bit ok;
         c = int'(warp_cls[2*w +: 2]);
         inf = 0;
         for (int k = 0; k < 4; k++) if (m_cnt[k] > 0 && m_own[k] == w) inf = 1;
         case (c)
            0: ok = (m_cnt[0] == 0) || (m_cnt[1] == 0);
            1: ok = (m_cnt[0] == 0) && (m_cnt[1] == 0);
            2: ok = (m_cnt[2] == 0);
            default: ok = (m_cnt[3] == 0);
         endcase
         rdy[w] = warp_valid[w] && !inf && ok;
      end
      for (int s = 0; s < 2; s++) begin
         pv[s] = 0; pl[s] = 0; pc[s] = 0;
         for (int i = 0; i < PER; i++) begin
            int j;
            j = (m_ptr[s] + i) % PER;
            if (!pv[s] && rdy[2*j+s]) begin
               pv[s] = 1; pl[s] = j; pc[s] = int'(warp_cls[2*(2*j+s) +: 2]);
            end
         end
      end
      for (int k = 0; k < 4; k++) used[k] = (m_cnt[k] > 0);
      ev[0] = pv[0]; ec[0] = 0; ev[1] = 0; ec[1] = 0;
      if (ev[0]) begin
         case (pc[0])
            0: ec[0] = used[0] ? 1 : 0;
            1: ec[0] = 0;
            2: ec[0] = 2;
            default: ec[0] = 3;
         endcase
         used[ec[0]] = 1;
         if (pc[0] == 1) used[1] = 1;
      end
      if (pv[1] && !(pv[0] && pc[0] == 1)) begin
         case (pc[1])
            0: if (!used[0]) begin ev[1] = 1; ec[1] = 0; end
               else if (!used[1]) begin ev[1] = 1; ec[1] = 1; end
            1: if (!pv[0]) begin ev[1] = 1; ec[1] = 0; end
            2: if (!used[2]) begin ev[1] = 1; ec[1] = 2; end
            default: if (!used[3]) begin ev[1] = 1; ec[1] = 3; end
         endcase
      end
      exp_busy = 0;
      for (int k = 0; k < 4; k++) if (m_cnt[k] > 0) exp_busy |= (1 << k);

      chk(iss_vld[0] == ev[0], "R3/R6 grant0", int'(iss_vld[0]), int'(ev[0]));
      chk(iss_vld[1] == ev[1], "R5/R6/R7 grant1", int'(iss_vld[1]), int'(ev[1]));
      if (ev[0] && iss_vld[0]) begin
         chk(int'(iss_warp0) == 2*pl[0], "R2 warp0", int'(iss_warp0), 2*pl[0]);
         chk(int'(iss_col0) == ec[0], "R4/R6 col0", int'(iss_col0), ec[0]);
      end
      if (ev[1] && iss_vld[1]) begin
         chk(int'(iss_warp1) == 2*pl[1]+1, "R2 warp1", int'(iss_warp1), 2*pl[1]+1);
         chk(int'(iss_col1) == ec[1], "R4/R5 col1", int'(iss_col1), ec[1]);
      end
      chk(int'(col_busy) == exp_busy, "R8/R9/R10 busy", int'(col_busy), exp_busy);

      // advance the model by one clock
      for (int k = 0; k < 4; k++) if (m_cnt[k] > 0) m_cnt[k]--;
      for (int s = 0; s < 2; s++) begin
         if (ev[s]) begin
            int hold;
            m_ptr[s] = (pl[s] + 1) % PER;
            hold = (ec[s] == 3) ? SHOLD : CHOLD;
            m_cnt[ec[s]] = hold - 1; m_own[ec[s]] = 2*pl[s] + s;
            if (pc[s] == 1) begin m_cnt[1] = CHOLD - 1; m_own[1] = 2*pl[s] + s; end
         end
      end
   endtask

   task automatic drive(input int density, input int mode);
      for (int w = 0; w < NW; w++) begin
         int c;
         warp_valid[w] = (($urandom % 100) < density);
         case (mode)
            0: c = 0;
            1: c = 3;
            2: c = (($urandom % 2) == 0) ? 0 : 2;
            3: c = $urandom % 4;
            default: c = (($urandom % 3) == 0) ? 1 : ($urandom % 4);
         endcase
         warp_cls[2*w +: 2] = 2'(c);
      end
   endtask

   initial begin
      for (int k = 0; k < 4; k++) begin m_cnt[k] = 0; m_own[k] = 0; end
      m_ptr[0] = 0; m_ptr[1] = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(iss_vld == 2'b00, "R1 no grant after reset", int'(iss_vld), 0);
      chk(col_busy == 4'b0000, "R1 columns idle after reset", int'(col_busy), 0);

      // Directed: pointer starts at warp 0/1 (R1), double from warp 0 blocks warp 1 (R6)
      @(negedge clk);
      warp_valid = '0; warp_valid[0] = 1'b1; warp_valid[1] = 1'b1;
      warp_valid[2] = 1'b1; warp_valid[3] = 1'b1;
      warp_cls = '0; warp_cls[1:0] = 2'd1; warp_cls[3:2] = 2'd2;
      #2;
      chk(iss_vld == 2'b01 && iss_warp0 == 0, "R1/R6 lone double from warp 0",
          int'(iss_vld), 1);
      step();
      // Directed: two load/store picks collide, scheduler 0 wins (R7)
      for (int n = 0; n < 6; n++) begin
         @(negedge clk);
         warp_cls = '0;
         for (int w = 0; w < 4; w++) warp_cls[2*w +: 2] = 2'd2;
         #2;
         step();
      end
      // Directed: one special-function warp, then core traffic alongside (R9)
      for (int n = 0; n < 12; n++) begin
         @(negedge clk);
         warp_valid = '0; warp_cls = '0;
         warp_valid[5] = (n == 0);
         warp_cls[11:10] = 2'd3;
         warp_valid[0] = (n > 0); warp_valid[2] = (n > 0);
         #2;
         step();
      end
      for (int ph = 0; ph < 6; ph++) begin
         for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            case (ph)
               0: drive(90, 0);
               1: drive(70, 1);
               2: drive(60, 2);
               3: drive(60, 3);
               4: drive(50, 4);
               default: drive(10, 3);
            endcase
            #2;
            step();
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule